// File: doc/BRIEF.md
# Flash Erase/Program Sequencer

This block guards and times the long write operations of an on-chip flash array. Software writes two registers through a small byte-wide port: a control register and an unlock register. An operation can begin only if the unlock register has just received a fixed two-byte key. It also needs write-enable set and the memory selector pointing at program memory. The operation is either a 32-byte row erase or the programming of one 32-bit unit taken from the write latches. The address comes from a 22-bit table pointer.

While the operation runs, the block holds the CPU stall output high for a parameterised number of clock cycles. When its internal counter expires, it changes the behavioural array, drops the stall, clears the start bit and pulses done for one cycle. It also reports how many instruction slots after the stall must be treated as lost: none after an erase and two after a program. Nominal erase time is about 2 ms. The durations are parameters, so a simulation can use short values.

Top module: `flash_seq_ctrl`

## Requirements
- R1: A control write with bit 0 (start) set launches an operation only if the two unlock-register writes just before it were 0x55 and then 0xAA. A start attempt without that key is ignored and sets `err`, which stays set until reset.
- R2: The key is voided by a wrong byte written to the unlock register (anything except 0xAA after 0x55) or by any control write between the key bytes. Every control write consumes the key.
- R3: An unlocked start launches only if bit 1 (write-enable) and bit 7 (memory-select, 1 = program memory) of the same control byte are set. Otherwise nothing happens and `err` is not set.
- R4: With bit 2 (erase-select) set, the operation sets all eight 32-bit words of the row addressed by pointer bits above bit 4 to 0xFFFFFFFF. Pointer bits 4:0 are ignored.
- R5: With bit 2 clear, the operation writes `latch_word` into the single 32-bit word addressed by pointer bits above bit 1. Pointer bits 1:0 are ignored, and no other word changes.
- R6: `stall` rises in the cycle after the launching write and stays high for exactly ERASE_CYC cycles (erase) or PROG_CYC cycles (program).
- R7: `done` is high for exactly one cycle, in the first cycle with `stall` low after an operation. `ctrl_q[0]` reads as 1 only while the operation runs.
- R8: `lost_slots` becomes 0 after an erase and 2 after a program, updated together with `done`, and otherwise holds.
- R9: Register writes made while `stall` is high have no effect on the operation, the key, the control fields or `err`.
- R10: After reset, `stall`, `done`, `err`, `lost_slots` and `ctrl_q[0]` are 0 and every array word reads 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = control register, 1 = unlock register |
| reg_wdata | input | 8 | Write data |
| tbl_ptr | input | 22 | Table pointer byte address |
| latch_word | input | 32 | Contents of the four byte write latches |
| rd_addr | input | IDX_W | Array word index for readback |
| rd_data | output | 32 | Array word at `rd_addr` |
| stall | output | 1 | CPU stall during a long write |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky flag for a start without the key |
| lost_slots | output | 2 | Instruction slots to be treated as lost after the last operation |
| ctrl_q | output | 8 | Control register readback, bit 0 = start/busy |

## Verification
The hardest situations to reach are those where the key looks complete but was broken partway: a stray byte inside the pair, a control write between 0x55 and 0xAA, or writes that arrive while the CPU is meant to be stalled. The stimulus writes those exact sequences and then a start. It then reads back the array words around the target and checks `err`. A cycle-level reference model tracks the key stage, the remaining cycles and the array contents, and is compared on every clock. Because of that, a write slipped in during a stall is caught at once if it has any effect.

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl #(
  parameter int ERASE_CYC   = 200000,
  parameter int PROG_CYC    = 200000,
  parameter int ARRAY_WORDS = 64,
  localparam int IDX_W = $clog2(ARRAY_WORDS),
  localparam int MAXC  = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC,
  localparam int CNT_W = $clog2(MAXC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic             reg_sel,
  input  logic [7:0]       reg_wdata,
  input  logic [21:0]      tbl_ptr,
  input  logic [31:0]      latch_word,
  input  logic [IDX_W-1:0] rd_addr,
  output logic [31:0]      rd_data,
  output logic             stall,
  output logic             done,
  output logic             err,
  output logic [1:0]       lost_slots,
  output logic [7:0]       ctrl_q
);
  localparam logic [1:0] K_IDLE = 2'd0, K_HALF = 2'd1, K_ARMED = 2'd2;

  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic             op_erase;
  logic [IDX_W-1:0] op_idx;
  logic [31:0]      op_data;
  logic [1:0]       key;
  logic             wren_q, erase_q, mem_q;
  logic [31:0]      mem [ARRAY_WORDS];

  wire ctl_wr = reg_we && !reg_sel && !busy;
  wire key_wr = reg_we &&  reg_sel && !busy;
  wire go_req = ctl_wr && reg_wdata[0];
  wire launch = go_req && key == K_ARMED && reg_wdata[1] && reg_wdata[7];
  wire finish = busy && cnt == '0;

  wire [IDX_W-1:0] word_idx = tbl_ptr[IDX_W+1:2];
  wire [IDX_W-1:0] row_idx  = {tbl_ptr[IDX_W+1:5], 3'b000};

  assign stall   = busy;
  assign ctrl_q  = {mem_q, 4'b0000, erase_q, wren_q, busy};
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; cnt <= '0; op_erase <= 1'b0; op_idx <= '0; op_data <= '0;
      key <= K_IDLE; wren_q <= 1'b0; erase_q <= 1'b0; mem_q <= 1'b0;
      done <= 1'b0; err <= 1'b0; lost_slots <= 2'd0;
    end else begin
      done <= finish;
      if (key_wr) begin
        if (reg_wdata == 8'h55)                        key <= K_HALF;
        else if (reg_wdata == 8'hAA && key == K_HALF)  key <= K_ARMED;
        else                                           key <= K_IDLE;
      end else if (ctl_wr) begin
        key <= K_IDLE;
      end
      if (ctl_wr) begin
        wren_q  <= reg_wdata[1];
        erase_q <= reg_wdata[2];
        mem_q   <= reg_wdata[7];
      end
      if (go_req && key != K_ARMED) err <= 1'b1;
      if (launch) begin
        busy     <= 1'b1;
        cnt      <= reg_wdata[2] ? CNT_W'(ERASE_CYC - 1) : CNT_W'(PROG_CYC - 1);
        op_erase <= reg_wdata[2];
        op_idx   <= reg_wdata[2] ? row_idx : word_idx;
        op_data  <= latch_word;
      end else if (busy) begin
        if (cnt == '0) begin
          busy       <= 1'b0;
          lost_slots <= op_erase ? 2'd0 : 2'd2;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < ARRAY_WORDS; g++) begin : g_word
    localparam logic [IDX_W-1:0] ME = IDX_W'(g);
    wire hit = op_erase ? (ME[IDX_W-1:3] == op_idx[IDX_W-1:3]) : (ME == op_idx);
    always_ff @(posedge clk) begin
      if (!rst_n)            mem[g] <= '1;
      else if (finish && hit) mem[g] <= op_erase ? '1 : op_data;
    end
  end
endmodule

// File: rtl/flash_seq_ctrl_chk.sv
module flash_seq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic       reg_sel,
  input logic [7:0] reg_wdata,
  input logic       stall,
  input logic       done,
  input logic       err,
  input logic [1:0] lost_slots,
  input logic [7:0] ctrl_q
);
  a_r1_err_sticky: assert property (@(posedge clk) disable iff (!rst_n) err |=> err);
  a_r6_stall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall) |-> $past(reg_we && !reg_sel && reg_wdata[0]));
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r7_done_after_stall: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!stall && $past(stall)));
  a_r7_start_cleared: assert property (@(posedge clk) disable iff (!rst_n) done |-> !ctrl_q[0]);
  a_r8_lost_legal: assert property (@(posedge clk) disable iff (!rst_n)
    lost_slots == 2'd0 || lost_slots == 2'd2);
  a_r8_lost_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(lost_slots));
  a_r9_err_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && $past(stall)) |-> $stable(err));
endmodule

bind flash_seq_ctrl flash_seq_ctrl_chk u_chk (.*);

// File: tb/sim_flash_seq_ctrl.sv
module sim_flash_seq_ctrl;
  localparam int EC = 20, PC = 12, NW = 64, IW = 6;
  logic clk = 0, rst_n = 0, reg_we = 0, reg_sel = 0;
  logic [7:0] reg_wdata = 0;
  logic [21:0] tbl_ptr = 0;
  logic [31:0] latch_word = 0;
  logic [IW-1:0] rd_addr = 0;
  logic [31:0] rd_data;
  logic stall, done, err;
  logic [1:0] lost_slots;
  logic [7:0] ctrl_q;
  int n_chk = 0, n_bad = 0, cyc = 0;

  flash_seq_ctrl #(.ERASE_CYC(EC), .PROG_CYC(PC), .ARRAY_WORDS(NW)) u0 (.*);

  always #5 clk = ~clk;

  // reference model
  int remain = 0, stage = 0, lost_m = 0, p_idx = 0;
  bit done_m = 0, err_m = 0, p_erase = 0;
  logic [31:0] p_data, mem_m [NW];

  always @(posedge clk) begin
    if (!rst_n) begin
      remain = 0; stage = 0; lost_m = 0; done_m = 0; err_m = 0;
      foreach (mem_m[i]) mem_m[i] = 32'hFFFFFFFF;
    end else begin
      bit was_busy;
      was_busy = remain > 0;
      done_m = 0;
      if (was_busy) begin
        remain--;
        if (remain == 0) begin
          done_m = 1;
          lost_m = p_erase ? 0 : 2;
          if (p_erase) for (int i = 0; i < 8; i++) mem_m[p_idx * 8 + i] = 32'hFFFFFFFF;
          else mem_m[p_idx] = p_data;
        end
      end else if (reg_we) begin
        if (reg_sel) begin
          if (reg_wdata == 8'h55) stage = 1;
          else if (reg_wdata == 8'hAA && stage == 1) stage = 2;
          else stage = 0;
        end else begin
          if (reg_wdata[0]) begin
            if (stage != 2) err_m = 1;
            else if (reg_wdata[1] && reg_wdata[7]) begin
              p_erase = reg_wdata[2];
              remain  = p_erase ? EC : PC;
              p_idx   = p_erase ? int'(tbl_ptr[IW+1:5]) : int'(tbl_ptr[IW+1:2]);
              p_data  = latch_word;
            end
          end
          stage = 0;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(stall == (remain > 0), "R6 stall", stall, remain > 0);
    chk(done == done_m, "R7 done", done, done_m);
    chk(ctrl_q[0] == (remain > 0), "R7 start bit", ctrl_q[0], remain > 0);
    chk(err == err_m, "R1 err", err, err_m);
    chk(lost_slots == lost_m, "R8 lost_slots", lost_slots, lost_m);
  end

  task automatic do_reset();
    @(negedge clk); rst_n = 0; reg_we = 0;
    repeat (2) @(negedge clk); rst_n = 1;
  endtask

  task automatic wr(input bit sel, input logic [7:0] d);
    reg_we = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic unlock();
    wr(1, 8'h55); wr(1, 8'hAA);
  endtask

  task automatic read_chk(input int idx, input logic [31:0] exp, input string tag);
    rd_addr = IW'(idx); #1;
    chk(rd_data == exp, tag, rd_data, exp);
  endtask

  task automatic run_op(input logic [7:0] ctl, input int n, input string tag);
    int len = 0;
    wr(0, ctl);
    while (stall && len < 1000) begin len++; @(negedge clk); end
    chk(len == n, tag, len, n);
    @(negedge clk);
  endtask

  initial begin
    do_reset();
    chk(!stall && !done && !err && lost_slots == 0 && !ctrl_q[0], "R10 outputs", {stall, done, err, ctrl_q[0]}, 0);
    read_chk(0, 32'hFFFFFFFF, "R10 array"); read_chk(63, 32'hFFFFFFFF, "R10 array");

    // R1: start with no key
    wr(0, 8'h83); @(negedge clk);
    chk(err && !stall, "R1 no key", err, 1);
    do_reset();

    // R5/R6/R8: program, low pointer bits ignored
    tbl_ptr = 22'h000013; latch_word = 32'h1234ABCD;
    unlock(); run_op(8'h83, PC, "R6 program length");
    read_chk(4, 32'h1234ABCD, "R5 target word"); read_chk(5, 32'hFFFFFFFF, "R5 neighbour");
    chk(lost_slots == 2, "R8 after program", lost_slots, 2);
    tbl_ptr = 22'h000024; latch_word = 32'h00C0FFEE;
    unlock(); run_op(8'h83, PC, "R6 program length");
    tbl_ptr = 22'h000040; latch_word = 32'h55AA0001;
    unlock(); run_op(8'h83, PC, "R6 program length");
    read_chk(9, 32'h00C0FFEE, "R5 word 9"); read_chk(16, 32'h55AA0001, "R5 word 16");

    // R4: erase row 1, pointer bits 4:0 ignored
    tbl_ptr = 22'h00002B;
    unlock(); run_op(8'h87, EC, "R6 erase length");
    read_chk(9, 32'hFFFFFFFF, "R4 row word erased");
    read_chk(4, 32'h1234ABCD, "R4 row 0 untouched");
    read_chk(16, 32'h55AA0001, "R4 row 2 untouched");
    chk(lost_slots == 0, "R8 after erase", lost_slots, 0);

    // R2: broken key sequences
    tbl_ptr = 22'h000000; latch_word = 32'hDEAD0000;
    wr(1, 8'h55); wr(1, 8'h12); wr(1, 8'hAA); wr(0, 8'h83); @(negedge clk);
    chk(!stall && err, "R2 stray byte", err, 1);
    read_chk(0, 32'hFFFFFFFF, "R2 no write");
    do_reset();
    wr(1, 8'h55); wr(0, 8'h82); wr(1, 8'hAA); wr(0, 8'h83); @(negedge clk);
    chk(!stall && err, "R2 control between", err, 1);
    do_reset();
    unlock(); wr(0, 8'h82); wr(0, 8'h83); @(negedge clk);
    chk(!stall && err, "R2 key consumed", err, 1);
    do_reset();

    // R3: missing write-enable / memory-select
    unlock(); wr(0, 8'h81); @(negedge clk);
    chk(!stall && !err, "R3 no wren", {stall, err}, 0);
    unlock(); wr(0, 8'h03); @(negedge clk);
    chk(!stall && !err, "R3 program memory not selected", {stall, err}, 0);
    read_chk(0, 32'hFFFFFFFF, "R3 array unchanged");

    // R9: writes during stall ignored
    tbl_ptr = 22'h000008; latch_word = 32'hA5A5A5A5;
    unlock(); wr(0, 8'h83);
    latch_word = 32'h0; wr(1, 8'h55); wr(1, 8'hAA); wr(0, 8'h87); wr(0, 8'h01);
    while (stall) @(negedge clk);
    @(negedge clk);
    chk(!err && !stall, "R9 no effect during stall", {err, stall}, 0);
    read_chk(2, 32'hA5A5A5A5, "R9 program kept");
    chk(ctrl_q[2] == 0, "R9 control fields unchanged", ctrl_q[2], 0);
    wr(0, 8'h83); @(negedge clk);
    chk(err && !stall, "R9 key not armed by stalled writes", err, 1);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=<100000", cyc);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule